// File: doc/BRIEF.md
# Parallel Port Host Cycle Sequencer

This block is the host end of an 8-bit byte-wide parallel peripheral link, the kind where one shared byte path carries both register selects and register contents. A local agent requests one transfer at a time with a start pulse, a two-bit operation code and a byte. The block then runs one bus cycle of that type. It sets the direction line. It drives the byte onto the pad or releases the pad. It lowers the matching active-low strobe. It then follows the peripheral's wait handshake through to the end of the cycle.

All timing is counted in system clocks. The setup gap before the strobe and the minimum time the direction line stays asserted are given in nanoseconds and are rounded up to whole cycles of the clock period. The wait input comes from another clock domain, so it passes through two flops before any decision uses it. A peripheral that never raises wait, or never drops it again, is abandoned after a set number of cycles. The block then frees the bus, reports the cycle as finished and flags the timeout.

The tri-state pad stays outside the block. It receives `bus_out` and `bus_oe`, and it returns the pin value on `bus_in`.

Top module: `epp_host_master`

## Requirements
- R1: `cmd_op[1]` selects a read (1) or a write (0), and `cmd_op[0]` selects the data strobe (1) or the address strobe (0). Only the selected strobe ever goes low, and the two strobes are never low together.
- R2: Starting in the first busy cycle and lasting until busy falls, a write holds `epp_dir` at 0, sets `bus_oe` to 1 and keeps the start-time `cmd_wdata` steady on `bus_out`. A read holds `epp_dir` at 1 with `bus_oe` at 0 over the same span. While idle, `epp_dir` is 1, `bus_oe` is 0 and `bus_out` is 0.
- R3: The selected strobe goes low exactly SETUP_CYC cycles after the first busy cycle. SETUP_CYC is ceil(SETUP_NS*1000/CLK_PS), which is 8 by default.
- R4: The strobe stays low for at least STB_MIN cycles, where STB_MIN = max(1, DIR_CYC - SETUP_CYC) and DIR_CYC = ceil(DIR_NS*1000/CLK_PS). It also stays low until the peripheral's wait, delayed by a two-flop synchronizer, is seen high. It is raised on the first edge where both conditions hold.
- R5: After the strobe rises, the block waits for synchronized wait to be low. On that edge `rsp_done` pulses high for one cycle and `busy` drops.
- R6: A read loads `bus_in` into `rsp_rdata` on the edge where the strobe is released. Writes and aborted cycles leave `rsp_rdata` unchanged.
- R7: The block aborts a cycle if synchronized wait has not risen within TIMEOUT_CYC cycles of the strobe falling. It also aborts if wait has not fallen within TIMEOUT_CYC cycles of the strobe rising. On an abort the strobe and the bus are released, `rsp_done` pulses, `rsp_timeout` goes to 1 and the block returns to idle.
- R8: `rsp_timeout` keeps its value until the next accepted start, which clears it to 0.
- R9: `cmd_start` is ignored while `busy` is 1. The cycle in progress is not altered, and no extra cycle follows.
- R10: After reset both strobes are high, `epp_dir` is 1, `bus_oe` is 0, and `busy`, `rsp_done`, `rsp_timeout` and `rsp_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request, taken only when idle |
| cmd_op | input | 2 | Bit 1 selects read, bit 0 selects the data strobe |
| cmd_wdata | input | 8 | Byte to send in write cycles |
| rsp_rdata | output | 8 | Byte captured by the last successful read |
| rsp_done | output | 1 | One-cycle pulse when a cycle ends |
| rsp_timeout | output | 1 | Last cycle was aborted for lack of a handshake |
| busy | output | 1 | A cycle is in progress |
| epp_astb_n | output | 1 | Address strobe, active low |
| epp_dstb_n | output | 1 | Data strobe, active low |
| epp_dir | output | 1 | 0 = host writes, 1 = host reads |
| epp_wait | input | 1 | Peripheral handshake, asynchronous |
| bus_out | output | 8 | Byte for the pad driver |
| bus_oe | output | 1 | Pad output enable |
| bus_in | input | 8 | Byte seen on the pad |

## Verification
The bench talks to a small peripheral model that stores an address on an address-strobe write and stores into a register file on a data-strobe write. The model responds with adjustable wait delays. An immediate response (delay 0) shows whether the minimum strobe width holds on its own. A mid-range delay shows whether the strobe tracks the handshake. A long delay that is still within the limit shows whether the timeout counter is measured from the correct phase.

Write-then-read pairs on distinct registers check three things at once: the operation decoding, the byte driven on the bus, and the byte captured on a read. A handshake that never rises and one that never falls each trigger an abort, and these separate the two timeout phases. A start pulse injected mid-cycle must leave both the sequence and the stored registers unchanged.

// File: rtl/epp_host_pkg.sv
`timescale 1ns/1ps
package epp_host_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RELEASE = 2'd3
  } phase_e;

  // whole clock cycles covering a span in nanoseconds, period in picoseconds
  function automatic int ns_to_cycles(input int span_ns, input int period_ps);
    return (span_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/epp_wait_sync.sv
`timescale 1ns/1ps
module epp_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/epp_span_counter.sv
`timescale 1ns/1ps
module epp_span_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             count <= '0;
    else if (clr)           count <= '0;
    else if (count != TOP)  count <= count + 1'b1;
endmodule

// File: rtl/epp_host_master.sv
`timescale 1ns/1ps
module epp_host_master
  import epp_host_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CLK_PS      = 5000,
  parameter int SETUP_NS    = 40,
  parameter int DIR_NS      = 80,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          rsp_timeout,
  output logic          busy,
  output logic          epp_astb_n,
  output logic          epp_dstb_n,
  output logic          epp_dir,
  input  logic          epp_wait,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in
);
  localparam int SETUP_CYC = at_least_one(ns_to_cycles(SETUP_NS, CLK_PS));
  localparam int DIR_CYC   = ns_to_cycles(DIR_NS, CLK_PS);
  localparam int STB_MIN   = at_least_one(DIR_CYC - SETUP_CYC);
  localparam int CW        = $clog2(max3(SETUP_CYC, STB_MIN, TIMEOUT_CYC) + 1);

  phase_e        ph_q, ph_d;
  logic          rd_q, dsel_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] elapsed;

  // named internal events
  logic wait_s, start_ok, setup_end, to_hit, stb_ok, rel_ok, abort_ev, finish_ev;
  logic stb_on, drive, el_clr;

  epp_wait_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(epp_wait), .sync_out(wait_s)
  );

  epp_span_counter #(.W(CW)) u_span (
    .clk(clk), .rst_n(rst_n), .clr(el_clr), .count(elapsed)
  );

  assign start_ok  = (ph_q == PH_IDLE) && cmd_start;
  assign setup_end = (ph_q == PH_SETUP) && (elapsed == CW'(SETUP_CYC - 1));
  assign to_hit    = (elapsed == CW'(TIMEOUT_CYC - 1));
  assign stb_ok    = (ph_q == PH_STROBE) && wait_s && (elapsed >= CW'(STB_MIN - 1));
  assign rel_ok    = (ph_q == PH_RELEASE) && !wait_s;
  assign abort_ev  = to_hit && (((ph_q == PH_STROBE) && !stb_ok) ||
                                ((ph_q == PH_RELEASE) && wait_s));
  assign finish_ev = rel_ok || abort_ev;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:    if (start_ok)  ph_d = PH_SETUP;
      PH_SETUP:   if (setup_end) ph_d = PH_STROBE;
      PH_STROBE:  if (stb_ok)    ph_d = PH_RELEASE;
                  else if (abort_ev) ph_d = PH_IDLE;
      PH_RELEASE: if (finish_ev) ph_d = PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
  end

  assign el_clr = (ph_d != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      rd_q        <= 1'b0;
      dsel_q      <= 1'b0;
      wdata_q     <= '0;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      rsp_done <= finish_ev;
      if (start_ok) begin
        rd_q        <= cmd_op[1];
        dsel_q      <= cmd_op[0];
        wdata_q     <= cmd_wdata;
        rsp_timeout <= 1'b0;
      end
      if (abort_ev)         rsp_timeout <= 1'b1;
      if (stb_ok && rd_q)   rsp_rdata   <= bus_in;
    end
  end

  assign busy       = (ph_q != PH_IDLE);
  assign drive      = busy;
  assign stb_on     = (ph_q == PH_STROBE);
  assign epp_astb_n = !(stb_on && !dsel_q);
  assign epp_dstb_n = !(stb_on && dsel_q);
  assign epp_dir    = drive ? rd_q : 1'b1;
  assign bus_oe     = drive && !rd_q;
  assign bus_out    = bus_oe ? wdata_q : '0;

endmodule

// File: rtl/epp_host_master_chk.sv
`timescale 1ns/1ps
module epp_host_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          busy,
  input logic          epp_astb_n,
  input logic          epp_dstb_n,
  input logic          epp_dir,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic          rsp_done,
  input logic          rsp_timeout,
  input logic          stb_on,
  input logic          wait_s,
  input logic          to_hit
);
  // R1
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!epp_astb_n && !epp_dstb_n));

  // R2
  p_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !epp_dir) |-> $stable(bus_out));

  // R3
  p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_on) |-> $past(busy));

  // R4
  p_hold_until_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_on && !wait_s && !to_hit) |=> stb_on);

  // R5
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R5
  p_idle_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_done);

  // R7
  p_abort_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_timeout) |-> (epp_astb_n && epp_dstb_n && !bus_oe));

  // R9
  p_start_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start) |=> busy);
endmodule

bind epp_host_master epp_host_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .busy(busy),
  .epp_astb_n(epp_astb_n), .epp_dstb_n(epp_dstb_n), .epp_dir(epp_dir),
  .bus_oe(bus_oe), .bus_out(bus_out), .rsp_done(rsp_done),
  .rsp_timeout(rsp_timeout), .stb_on(stb_on), .wait_s(wait_s), .to_hit(to_hit)
);

// File: tb/epp_host_master_test.sv
`timescale 1ns/1ps
module epp_host_master_test;
  localparam int TO    = 60;
  localparam int SETUP = (40 * 1000 + 4999) / 5000;      // 8
  localparam int DIRC  = (80 * 1000 + 4999) / 5000;      // 16
  localparam int SMIN  = (DIRC - SETUP < 1) ? 1 : DIRC - SETUP;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_wdata = 8'h00;
  logic [7:0] rsp_rdata, bus_out, bus_in;
  logic       rsp_done, rsp_timeout, busy, epp_astb_n, epp_dstb_n, epp_dir, bus_oe;
  logic       epp_wait = 1'b0;

  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  epp_host_master #(.TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .rsp_timeout(rsp_timeout), .busy(busy), .epp_astb_n(epp_astb_n),
    .epp_dstb_n(epp_dstb_n), .epp_dir(epp_dir), .epp_wait(epp_wait),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  // ---------------- peripheral model ----------------
  int         rise_dly = 0, fall_dly = 0, pcnt = 0;
  logic [7:0] p_addr = 8'h00;
  logic [7:0] p_regs [8];

  initial for (int i = 0; i < 8; i++) p_regs[i] = 8'h00;

  assign bus_in = epp_dir ? (epp_astb_n ? p_regs[p_addr[2:0]] : p_addr) : 8'h00;

  always @(negedge clk) begin
    if (!rst_n) begin
      epp_wait <= 1'b0; pcnt = 0;
    end else if ((!epp_astb_n || !epp_dstb_n) && !epp_wait) begin
      if (pcnt >= rise_dly) begin
        epp_wait <= 1'b1; pcnt = 0;
        if (!epp_dir) begin
          if (!epp_astb_n) p_addr = bus_out;
          else             p_regs[p_addr[2:0]] = bus_out;
        end
      end else pcnt++;
    end else if (epp_astb_n && epp_dstb_n && epp_wait) begin
      if (pcnt >= fall_dly) begin epp_wait <= 1'b0; pcnt = 0; end
      else pcnt++;
    end else pcnt = 0;
  end

  // ---------------- reference model ----------------
  int         m_ph = 0, m_el = 0;
  bit         m_rd = 0, m_ds = 0, m_done = 0, m_to = 0, m_w1 = 0, m_w2 = 0;
  logic [7:0] m_wd = 0, m_rdata = 0;

  always @(posedge clk) begin
    bit ws;
    bit moved;
    ws = m_w2; m_w2 = m_w1; m_w1 = epp_wait;
    moved = 0;
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_rd = 0; m_ds = 0; m_done = 0; m_to = 0;
      m_w1 = 0; m_w2 = 0; m_wd = 0; m_rdata = 0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (cmd_start) begin
          m_ph = 1; moved = 1; m_rd = cmd_op[1]; m_ds = cmd_op[0];
          m_wd = cmd_wdata; m_to = 0;
        end
      end else if (m_ph == 1) begin
        if (m_el == SETUP - 1) begin m_ph = 2; moved = 1; end
      end else if (m_ph == 2) begin
        if (ws && m_el >= SMIN - 1) begin
          if (m_rd) m_rdata = bus_in;
          m_ph = 3; moved = 1;
        end else if (m_el == TO - 1) begin
          m_ph = 0; moved = 1; m_to = 1; m_done = 1;
        end
      end else begin
        if (!ws) begin m_ph = 0; moved = 1; m_done = 1; end
        else if (m_el == TO - 1) begin m_ph = 0; moved = 1; m_to = 1; m_done = 1; end
      end
      m_el = moved ? 0 : m_el + 1;
    end
  end

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit on, act_drv;
    on = (m_ph == 2);
    act_drv = (m_ph != 0);
    cmp("R1", "astb_n", epp_astb_n, !(on && !m_ds));
    cmp("R3", "dstb_n", epp_dstb_n, !(on && m_ds));
    cmp("R2", "dir", epp_dir, act_drv ? m_rd : 1'b1);
    cmp("R2", "bus_oe", bus_oe, act_drv && !m_rd);
    cmp("R2", "bus_out", bus_out, (act_drv && !m_rd) ? m_wd : 8'h00);
    cmp("R5", "busy", busy, act_drv);
    cmp("R5", "done", rsp_done, m_done);
    cmp("R7", "timeout", rsp_timeout, m_to);
    cmp("R6", "rdata", rsp_rdata, m_rdata);
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start(input logic [1:0] op, input logic [7:0] d);
    @(posedge clk); #1; cmd_start = 1'b1; cmd_op = op; cmd_wdata = d;
    @(posedge clk); #1; cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!rsp_done);
    repeat (2) @(posedge clk);
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] d);
    pulse_start(op, d);
    wait_done();
  endtask

  task automatic settle();
    while (epp_wait) @(negedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic body();
    repeat (4) @(posedge clk);
    @(negedge clk);
    cmp("R10", "reset busy", busy, 0);                     // R10
    cmp("R10", "reset strobes", {epp_astb_n, epp_dstb_n}, 2'b11);
    @(posedge clk); #1; rst_n = 1'b1;

    rise_dly = 3; fall_dly = 2;
    run(2'b00, 8'h02); run(2'b01, 8'h5A);                  // R1 writes
    run(2'b00, 8'h05); run(2'b01, 8'hC3);
    run(2'b10, 8'h00);
    cmp("R6", "addr readback", rsp_rdata, 8'h05);          // R6
    run(2'b11, 8'h00);
    cmp("R1", "reg5 readback", rsp_rdata, 8'hC3);          // R1

    rise_dly = 0; fall_dly = 0;
    run(2'b00, 8'h02); run(2'b11, 8'h00);
    cmp("R4", "fast peer read", rsp_rdata, 8'h5A);         // R4

    rise_dly = 12; fall_dly = 9;
    pulse_start(2'b11, 8'h00);
    repeat (5) @(posedge clk); #1;
    cmd_start = 1'b1; cmd_op = 2'b01; cmd_wdata = 8'hFF;   // R9 poke while busy
    @(posedge clk); #1; cmd_start = 1'b0;
    wait_done();
    run(2'b11, 8'h00);
    cmp("R9", "reg2 untouched", rsp_rdata, 8'h5A);         // R9

    rise_dly = 100000;                                     // R7 no rise
    run(2'b01, 8'h77);
    cmp("R7", "strobe-phase abort", rsp_timeout, 1);
    cmp("R7", "reg2 after abort", p_regs[2], 8'h5A);
    rise_dly = 2; settle();
    cmp("R8", "flag held", rsp_timeout, 1);                // R8
    run(2'b11, 8'h00);
    cmp("R8", "flag cleared", rsp_timeout, 0);

    rise_dly = 2; fall_dly = 100000;                       // R7 no fall
    run(2'b10, 8'h00);
    cmp("R7", "release-phase abort", rsp_timeout, 1);
    fall_dly = 3; settle();
    run(2'b11, 8'h00);
    cmp("R8", "clear after recovery", rsp_timeout, 0);
    cmp("R6", "final read", rsp_rdata, 8'h5A);
  endtask

  initial begin
    fork
      body();
      begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL R5 watchdog actual hung expected done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule